// File: doc/BRIEF.md
# 5B Receive Code-Group Decoder with Start-Delimiter Checking

This block sits after the descrambler in a 100 Mb/s twisted-pair receive path. It takes one serial bit per qualified clock and is not yet aligned to code-group boundaries. It hunts for the start of a stream and fixes the 5-bit boundary from the position of the first zero after a run of idle ones. It then turns each 5-bit code-group into a 4-bit receive nibble with data-valid, error and carrier flags, in the style of an MII receive interface. Code-groups travel most significant bit first: the group written 11000 arrives as 1, 1, 0, 0, 0.

A well-formed stream opens with the start pair 11000 10001 and carries 4B/5B data groups. It closes either with the end pair 01101 00111 or with two idle groups (11111). A stream that leaves idle without the start pair is a false carrier. The block then flags every group as an error with the nibble 1110 until two idle groups arrive. It also emits a one-cycle event and bumps a saturating false-carrier count. A low link-up input forces every output inactive and drops any partly received stream.

Top module: `rx5b_decoder`

## Requirements
- R1: While hunting, a zero on a valid bit opens a stream only when at least IDLE_LEAD (default 10) consecutive valid ones came just before it, or when the previous stream ended on two idle groups. A zero without that lead is ignored, and all outputs stay low.
- R2: The first zero of an opened stream is the third bit of the first code-group. That group and every later one follow this 5-bit boundary. Outputs update on the clock edge that takes in the fifth bit of each group.
- R3: If the first group is 11000, CRS goes high with RXD = 0101, while RX_DV and RX_ER stay low.
- R4: If 10001 follows 11000, RX_DV goes high with RXD = 0101, and the stream enters the data phase.
- R5: In the data phase, each data group gives its 4-bit value on RXD with RX_ER low. The sixteen data groups for values 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: In the data phase, the group 01101 drops CRS, RX_DV and RX_ER and sets RXD to 0. The next group (00111 expected) is consumed, and the block then hunts again.
- R7: In the data phase or a false carrier, the second of two consecutive 11111 groups drops all flags and RXD to 0. The first of them is reported with RX_ER high.
- R8: In the data phase, any group that is not a data group raises RX_ER with RXD = 1110, and RX_DV and CRS stay high. This covers 11111 (when the next group is not also 11111), 11000, 10001, 00111, 00100 and the eight codes 00000, 00001, 00010, 00011, 00101, 00110, 01000, 01100.
- R9: A first group other than 11000, or a 11000 followed by anything but 10001, is a false carrier. From that group on, each group gives CRS = 1, RX_ER = 1, RX_DV = 0 and RXD = 1110, until two consecutive 11111 groups end it (R7).
- R10: Each false-carrier start raises fc_pulse for exactly one cycle, on the edge that sets RX_ER. fc_count rises by one on that same edge.
- R11: fc_count (FC_W bits, default 16) holds at its all-ones value once reached. Only reset clears it.
- R12: While link_up is low, from the next edge on, RXD, RX_DV, RX_ER, CRS and fc_pulse are 0 and any stream is dropped. fc_count holds its value, and the idle lead of R1 must be seen again.
- R13: Bits with bit_vld low have no effect.
- R14: After reset all outputs, including fc_count, are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | High when the link is usable; low holds outputs inactive |
| bit_in | input | 1 | Descrambled serial bit |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |
| fc_pulse | output | 1 | One-cycle false-carrier event |
| fc_count | output | FC_W | Saturating false-carrier count |

## Verification
The bench targets the boundary rule. A design that places the boundary one bit off decodes the start pair as garbage and reports a false carrier where a good frame was sent. The bench also sends zeros with too short an idle lead; a block that opens on them would raise CRS on noise. It checks both ways a start can fail, after the first group and after the second. A design that only checks 11000 would pass an unchecked second group as valid data. A single idle inside a frame must raise an error and must not end the frame. Frames are also closed in both ways, with the end pair and with two idles, to catch a block that misses either ending. The bench also drops the link mid-frame and drives the false-carrier count past its limit with a narrowed width, so a wrapping or reset-on-link-loss counter shows up as a wrong value.

// File: rtl/rx5b_pkg.sv
package rx5b_pkg;

  typedef enum logic [2:0] {
    CG_DATA,
    CG_IDLE,
    CG_SOS1,
    CG_SOS2,
    CG_EOS1,
    CG_EOS2,
    CG_BAD
  } cg_kind_t;

  typedef struct packed {
    cg_kind_t   kind;
    logic [3:0] nib;
  } cg_dec_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_FIRST,
    ST_SECOND,
    ST_DATA,
    ST_TAIL,
    ST_FALSE
  } rx_state_t;

  localparam logic [3:0] ERR_NIB = 4'b1110;
  localparam logic [3:0] PRE_NIB = 4'b0101;

  function automatic cg_dec_t decode_group(input logic [4:0] g);
    cg_dec_t d;
    d.kind = CG_DATA;
    d.nib  = 4'h0;
    case (g)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      5'b11111: d.kind = CG_IDLE;
      5'b11000: d.kind = CG_SOS1;
      5'b10001: d.kind = CG_SOS2;
      5'b01101: d.kind = CG_EOS1;
      5'b00111: d.kind = CG_EOS2;
      default:  d.kind = CG_BAD;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rx5b_align.sv
module rx5b_align #(
  parameter int IDLE_LEAD = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       bit_in,
  input  logic       bit_vld,
  input  logic       hunt,
  input  logic       rearm,
  output logic       start,
  output logic       grp_done,
  output logic [4:0] grp
);
  localparam int OW = $clog2(IDLE_LEAD + 1);
  localparam logic [OW-1:0] LEAD = OW'(IDLE_LEAD);

  logic [OW-1:0] ones_q;
  logic [3:0]    sh_q;
  logic [2:0]    cnt_q;
  logic          armed;

  assign armed    = (ones_q == LEAD);
  assign start    = bit_vld && hunt && !bit_in && armed;
  assign grp_done = bit_vld && !hunt && (cnt_q == 3'd4);
  assign grp      = {sh_q, bit_in};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      if (rearm) begin
        ones_q <= LEAD;
      end else if (!hunt) begin
        ones_q <= '0;
      end else if (bit_vld) begin
        if (bit_in) ones_q <= armed ? ones_q : ones_q + 1'b1;
        else        ones_q <= '0;
      end

      if (bit_vld) begin
        if (hunt) begin
          if (start) begin
            sh_q  <= 4'b0110;
            cnt_q <= 3'd3;
          end
        end else begin
          sh_q  <= {sh_q[2:0], bit_in};
          cnt_q <= (cnt_q == 3'd4) ? 3'd0 : cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx5b_code_lut.sv
module rx5b_code_lut
  import rx5b_pkg::*;
(
  input  logic [4:0] grp,
  output cg_kind_t   kind,
  output logic [3:0] nib
);
  cg_dec_t d;
  always_comb begin
    d    = decode_group(grp);
    kind = d.kind;
    nib  = d.nib;
  end
endmodule

// File: rtl/rx5b_fc_cnt.sv
module rx5b_fc_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                     count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/rx5b_decoder.sv
module rx5b_decoder
  import rx5b_pkg::*;
#(
  parameter int IDLE_LEAD = 10,
  parameter int FC_W      = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            link_up,
  input  logic            bit_in,
  input  logic            bit_vld,
  output logic [3:0]      rxd,
  output logic            rx_dv,
  output logic            rx_er,
  output logic            crs,
  output logic            fc_pulse,
  output logic [FC_W-1:0] fc_count
);
  rx_state_t  state_q;
  logic       prev_idle_q;
  logic       start, grp_done, rearm, fc_hit;
  logic [4:0] grp;
  cg_kind_t   kind;
  logic [3:0] nib;

  rx5b_align #(.IDLE_LEAD(IDLE_LEAD)) align_i (
    .clk(clk), .rst(rst), .clr(!link_up),
    .bit_in(bit_in), .bit_vld(bit_vld),
    .hunt(state_q == ST_HUNT), .rearm(rearm),
    .start(start), .grp_done(grp_done), .grp(grp)
  );

  rx5b_code_lut lut_i (.grp(grp), .kind(kind), .nib(nib));

  // end of stream on a second consecutive idle group
  assign rearm = link_up && grp_done && prev_idle_q && (kind == CG_IDLE) &&
                 (state_q == ST_DATA || state_q == ST_FALSE);

  // false carrier raised on the first or second start group
  assign fc_hit = link_up && grp_done &&
                  ((state_q == ST_FIRST  && kind != CG_SOS1) ||
                   (state_q == ST_SECOND && kind != CG_SOS2));

  rx5b_fc_cnt #(.W(FC_W)) cnt_i (.clk(clk), .rst(rst), .inc(fc_hit), .count(fc_count));

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      state_q     <= ST_HUNT;
      prev_idle_q <= 1'b0;
      rxd         <= 4'h0;
      rx_dv       <= 1'b0;
      rx_er       <= 1'b0;
      crs         <= 1'b0;
      fc_pulse    <= 1'b0;
    end else begin
      fc_pulse <= fc_hit;
      if (start) state_q <= ST_FIRST;
      if (grp_done) begin
        case (state_q)
          ST_FIRST: begin
            crs         <= 1'b1;
            prev_idle_q <= 1'b0;
            if (kind == CG_SOS1) begin
              rxd     <= PRE_NIB;
              state_q <= ST_SECOND;
            end else begin
              rxd     <= ERR_NIB;
              rx_er   <= 1'b1;
              state_q <= ST_FALSE;
            end
          end
          ST_SECOND: begin
            if (kind == CG_SOS2) begin
              rxd     <= PRE_NIB;
              rx_dv   <= 1'b1;
              state_q <= ST_DATA;
            end else begin
              rxd     <= ERR_NIB;
              rx_er   <= 1'b1;
              state_q <= ST_FALSE;
            end
          end
          ST_DATA: begin
            prev_idle_q <= (kind == CG_IDLE);
            if (rearm) begin
              rxd <= 4'h0; rx_dv <= 1'b0; rx_er <= 1'b0; crs <= 1'b0;
              state_q <= ST_HUNT;
            end else if (kind == CG_DATA) begin
              rxd   <= nib;
              rx_er <= 1'b0;
            end else if (kind == CG_EOS1) begin
              rxd <= 4'h0; rx_dv <= 1'b0; rx_er <= 1'b0; crs <= 1'b0;
              state_q <= ST_TAIL;
            end else begin
              rxd   <= ERR_NIB;
              rx_er <= 1'b1;
            end
          end
          ST_TAIL: state_q <= ST_HUNT;
          ST_FALSE: begin
            prev_idle_q <= (kind == CG_IDLE);
            if (rearm) begin
              rxd <= 4'h0; rx_er <= 1'b0; crs <= 1'b0;
              state_q <= ST_HUNT;
            end else begin
              rxd   <= ERR_NIB;
              rx_er <= 1'b1;
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx5b_decoder_chk.sv
module rx5b_decoder_chk #(
  parameter int FC_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            link_up,
  input logic [3:0]      rxd,
  input logic            rx_dv,
  input logic            rx_er,
  input logic            crs,
  input logic            fc_pulse,
  input logic [FC_W-1:0] fc_count
);
  localparam logic [FC_W-1:0] TOP = '1;

  // R4: valid data always rides on carrier
  a_r4_dv_needs_crs: assert property (@(posedge clk) disable iff (rst)
    rx_dv |-> crs);

  // R9: outside a valid stream an error always shows the fixed nibble
  a_r9_false_nibble: assert property (@(posedge clk) disable iff (rst)
    (rx_er && !rx_dv) |-> (rxd == 4'b1110 && crs));

  // R10: each event adds one to the count below the ceiling
  a_r10_event_counts: assert property (@(posedge clk) disable iff (rst)
    (fc_pulse && $past(fc_count) != TOP) |-> fc_count == $past(fc_count) + 1'b1);

  // R10: the count moves only with an event
  a_r10_no_silent_change: assert property (@(posedge clk) disable iff (rst)
    !fc_pulse |-> $stable(fc_count));

  // R10: the event comes with an error flag
  a_r10_pulse_with_error: assert property (@(posedge clk) disable iff (rst)
    fc_pulse |-> (rx_er && crs && !rx_dv));

  // R11: saturation holds the top value
  a_r11_saturate: assert property (@(posedge clk) disable iff (rst)
    ($past(fc_count) == TOP) |-> fc_count == TOP);

  // R12: link down silences the outputs from the next edge
  a_r12_link_quiet: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (!crs && !rx_dv && !rx_er && !fc_pulse && rxd == 4'h0));
endmodule

bind rx5b_decoder rx5b_decoder_chk #(.FC_W(FC_W)) chk_i (
  .clk(clk), .rst(rst), .link_up(link_up), .rxd(rxd), .rx_dv(rx_dv),
  .rx_er(rx_er), .crs(crs), .fc_pulse(fc_pulse), .fc_count(fc_count)
);

// File: tb/rx5b_decoder_tb_top.sv
`timescale 1ns/100ps
module rx5b_decoder_tb_top;
  localparam int FC_W = 3;
  localparam logic [4:0] G_I = 5'b11111, G_J = 5'b11000, G_K = 5'b10001,
                         G_T = 5'b01101, G_R = 5'b00111, G_H = 5'b00100;

  logic clk = 1'b0, rst = 1'b1, link_up = 1'b1, bit_in = 1'b1, bit_vld = 1'b0;
  logic [3:0] rxd;
  logic rx_dv, rx_er, crs, fc_pulse;
  logic [FC_W-1:0] fc_count;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit use_gaps = 1'b0;

  always #2.5 clk = ~clk;

  rx5b_decoder #(.IDLE_LEAD(10), .FC_W(FC_W)) dut_i (
    .clk(clk), .rst(rst), .link_up(link_up), .bit_in(bit_in), .bit_vld(bit_vld),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs),
    .fc_pulse(fc_pulse), .fc_count(fc_count)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100;
      4'h3: return 5'b10101; 4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111; 4'h8: return 5'b10010;
      4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100;
      default: return 5'b11101;
    endcase
  endfunction

  // send one group MSB first; optional idle cycles with junk on bit_in (R13)
  task automatic send(input logic [4:0] g);
    for (int i = 4; i >= 0; i--) begin
      if (use_gaps) begin
        int gap = $urandom_range(0, 2);
        for (int k = 0; k < gap; k++) begin
          @(negedge clk); bit_vld = 1'b0; bit_in = $urandom_range(0, 1);
        end
      end
      @(negedge clk); bit_in = g[i]; bit_vld = 1'b1;
    end
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic chk(input string tag, input logic e_crs, input logic e_dv,
                     input logic e_er, input logic [3:0] e_rxd, input bit use_rxd);
    checks++;
    if (crs !== e_crs || rx_dv !== e_dv || rx_er !== e_er || (use_rxd && rxd !== e_rxd)) begin
      errors++;
      $display("FAIL %s: crs/dv/er/rxd=%b%b%b/%h expected %b%b%b/%h",
               tag, crs, rx_dv, rx_er, rxd, e_crs, e_dv, e_er, e_rxd);
    end
  endtask

  task automatic chk_v(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int fc_exp = 0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R14 reset outputs", 0, 0, 0, 4'h0, 1);
    chk_v("R14 reset count", fc_count, 0);

    // R1: start pair with only seven ones of lead is ignored
    send(G_I); send(G_J); chk("R1 short lead J", 0, 0, 0, 4'h0, 1);
    send(G_K); chk("R1 short lead K", 0, 0, 0, 4'h0, 1);
    send(G_I); send(G_I); chk("R1 idle while hunting", 0, 0, 0, 4'h0, 1);

    // good frame with end pair
    send(G_J); chk("R3 first start group", 1, 0, 0, 4'b0101, 1);
    send(G_K); chk("R4 second start group", 1, 1, 0, 4'b0101, 1);
    for (int n = 0; n < 16; n++) begin
      send(enc(4'(n))); chk($sformatf("R5 R2 data nibble %h", n), 1, 1, 0, 4'(n), 1);
    end
    send(G_T); chk("R6 end group", 0, 0, 0, 4'h0, 1);
    send(G_R); chk("R6 after end pair", 0, 0, 0, 4'h0, 1);

    // random frames with gapped bits, closed by two idles
    use_gaps = 1'b1;
    for (int p = 0; p < 4; p++) begin
      int len = $urandom_range(4, 12);
      send(G_I); send(G_I);
      send(G_J); chk("R3 random frame J", 1, 0, 0, 4'b0101, 1);
      send(G_K); chk("R4 random frame K", 1, 1, 0, 4'b0101, 1);
      for (int i = 0; i < len; i++) begin
        logic [3:0] v = 4'($urandom_range(0, 15));
        send(enc(v)); chk("R13 R5 random data", 1, 1, 0, v, 1);
      end
      if (p[0]) begin
        send(G_T); chk("R6 random end", 0, 0, 0, 4'h0, 1);
        send(G_R);
      end else begin
        send(G_I); chk("R7 first idle", 1, 1, 1, 4'b1110, 1);
        send(G_I); chk("R7 second idle", 0, 0, 0, 4'h0, 1);
      end
    end
    use_gaps = 1'b0;

    // errors inside a frame
    send(G_I); send(G_I); send(G_J); send(G_K);
    send(enc(4'h3)); chk("R5 before error", 1, 1, 0, 4'h3, 1);
    send(G_H); chk("R8 halt code", 1, 1, 1, 4'b1110, 1);
    send(5'b00000); chk("R8 invalid code", 1, 1, 1, 4'b1110, 1);
    send(G_J); chk("R8 start group in data", 1, 1, 1, 4'b1110, 1);
    send(G_R); chk("R8 stray end group", 1, 1, 1, 4'b1110, 1);
    send(G_I); chk("R8 lone idle", 1, 1, 1, 4'b1110, 1);
    send(enc(4'hA)); chk("R8 data after lone idle", 1, 1, 0, 4'hA, 1);
    send(G_I); send(G_I); chk("R7 frame closed", 0, 0, 0, 4'h0, 1);

    // false carrier on first group (rearmed by the two idles just sent)
    send(5'b11010); fc_exp++;
    chk("R9 bad first group", 1, 0, 1, 4'b1110, 1);
    chk_v("R10 pulse on first group", fc_pulse, 1);
    chk_v("R10 count first", fc_count, fc_exp);
    send(enc(4'h5)); chk("R9 false carrier data", 1, 0, 1, 4'b1110, 1);
    chk_v("R10 pulse one cycle", fc_pulse, 0);
    send(G_I); chk("R9 first idle", 1, 0, 1, 4'b1110, 1);
    send(G_I); chk("R7 false carrier closed", 0, 0, 0, 4'h0, 1);

    // false carrier on second group
    send(G_J); chk("R3 start before bad K", 1, 0, 0, 4'b0101, 1);
    send(5'b01110); fc_exp++;
    chk("R9 bad second group", 1, 0, 1, 4'b1110, 1);
    chk_v("R10 pulse on second group", fc_pulse, 1);
    chk_v("R10 count second", fc_count, fc_exp);
    send(G_I); send(G_I); chk("R7 closed again", 0, 0, 0, 4'h0, 1);

    // link loss mid frame
    send(G_J); send(G_K); send(enc(4'h9));
    @(negedge clk); link_up = 1'b0;
    @(negedge clk); chk("R12 link down quiet", 0, 0, 0, 4'h0, 1);
    chk_v("R12 count held", fc_count, fc_exp);
    send(G_J); chk("R12 no decode while down", 0, 0, 0, 4'h0, 1);
    link_up = 1'b1;
    send(G_J); chk("R12 R1 lead needed after link up", 0, 0, 0, 4'h0, 1);
    send(G_I); send(G_I);
    send(G_J); chk("R12 recovered", 1, 0, 0, 4'b0101, 1);
    send(G_K); send(G_T); send(G_R);

    // saturation of a 3-bit count
    for (int e = 0; e < 8; e++) begin
      send(G_I); send(G_I); send(5'b11011);
      if (fc_exp < 7) fc_exp++;
      chk_v("R11 count while saturating", fc_count, fc_exp);
      send(G_I); send(G_I);
    end
    chk_v("R11 saturated value", fc_count, 7);

    finish_run();
  end
endmodule